// File: doc/BRIEF.md
# Single-Precision Floating-Point Comparator with Sticky Invalid Flag

This unit compares two IEEE-754 single-precision operands and returns one result bit. A 3-bit operation code picks one of six relational tests or an unordered test. The relational tests do not all read the operands in the same order. The less-than code evaluates B < A. The greater-than code evaluates A < B, and greater-or-equal is the complement of that test. Less-or-equal evaluates A <= B. Equal and not-equal are quiet compares, and not-equal is the complement of equal.

The unit keeps a sticky invalid-operation bit. The ordered compares (lt, le, gt, ge) set this bit for any NaN operand. The unordered, eq and ne codes set it only for a signaling NaN. When an invalid condition arises and both enables are high, the unit raises a one-cycle exception request: the global exception enable and the FPU-exception configuration enable. A caller asserts the valid strobe for one cycle and reads the result on the following cycle.

Top module: `fcmp_unit`

## Requirements
- R1: Code 0 (unordered) returns 1 when either operand is a NaN of either kind. It flags invalid only when at least one operand is a signaling NaN.
- R2: Code 1 (lt) returns 1 when B is strictly less than A, and returns 0 if either operand is NaN.
- R3: Code 4 (gt) returns A < B. Code 6 (ge) returns the complement of A < B, so ge returns 1 whenever an operand is NaN.
- R4: Code 3 (le) returns A <= B, and returns 0 if either operand is NaN.
- R5: Code 2 (eq) returns 1 for equal non-NaN operands. Code 5 (ne) returns its complement, so ne returns 1 whenever an operand is NaN. Both flag invalid only for a signaling NaN; a quiet NaN leaves the flag clear.
- R6: Codes 1, 3, 4 and 6 flag invalid when either operand is any NaN.
- R7: The invalid flag is sticky. Once set it stays set until reset, and compares that raise no invalid do not clear it.
- R8: exc_req_o is high for the cycle after a strobe only when that strobe flagged invalid and both exc_en_i and fpu_exc_cfg_i were high. It is 0 in every other cycle.
- R9: +0 and -0 compare equal. Non-NaN operands are ordered as signed magnitudes, with -inf lowest and +inf highest, and denormals included.
- R10: A NaN has all exponent bits set and a nonzero fraction. It is quiet when fraction bit 22 (operand bit 22) is 1 and signaling when that bit is 0.
- R11: Reset clears result_o, inv_sticky_o and exc_req_o. result_o and the flag update on the clock edge where valid_i is high. In cycles without a strobe, result_o holds its value and exc_req_o is 0.
- R12: Code 7 is reserved. It returns 0 and never flags invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Compare strobe |
| op_i | input | 3 | Operation code (0 unord, 1 lt, 2 eq, 3 le, 4 gt, 5 ne, 6 ge, 7 reserved) |
| a_i | input | 1+EXP_W+FRAC_W (32) | Operand A |
| b_i | input | 1+EXP_W+FRAC_W (32) | Operand B |
| exc_en_i | input | 1 | Global exception enable |
| fpu_exc_cfg_i | input | 1 | FPU-exception configuration enable |
| result_o | output | 1 | Registered compare result |
| inv_sticky_o | output | 1 | Sticky invalid-operation flag |
| exc_req_o | output | 1 | One-cycle FPU exception request |

## Verification
The unit holds only three bits of state, so any fault in it shows on the first strobe that depends on it. A stuck or self-clearing sticky bit is visible when a NaN compare is followed by clean compares. A swapped operand order shows at once as a wrong result on an asymmetric pair such as 1.0 against 2.0. A wrong quiet/signaling decode shows as a flag or a request one cycle after a quiet-NaN eq, or after an unordered compare. The bench sweeps every code across a set of operands that covers both zeros, both infinities, denormals and both NaN kinds. It resets between phases so that each flag transition can be seen on its own.

// File: rtl/fcmp_pkg.sv
`timescale 1ns/1ps
package fcmp_pkg;

   typedef enum logic [2:0] {
      OP_UNORD = 3'd0,
      OP_LT    = 3'd1,
      OP_EQ    = 3'd2,
      OP_LE    = 3'd3,
      OP_GT    = 3'd4,
      OP_NE    = 3'd5,
      OP_GE    = 3'd6,
      OP_RSVD  = 3'd7
   } fcmp_op_e;

   // per-operand classification
   typedef struct packed {
      logic sign;
      logic zero;
      logic nan;
      logic snan;
   } fcmp_cls_t;

   // outcome of one decoded compare before registering
   typedef struct packed {
      logic res;
      logic inv;
   } fcmp_out_t;

endpackage

// File: rtl/fcmp_classify.sv
`timescale 1ns/1ps
module fcmp_classify
   import fcmp_pkg::*;
#(
   parameter int EXP_W         = 8,
   parameter int FRAC_W        = 23,
   parameter bit QUIET_MSB_SET = 1'b1
) (
   input  logic [EXP_W+FRAC_W:0] val_i,
   output fcmp_cls_t             cls_o
);

   localparam int W = 1 + EXP_W + FRAC_W;

   logic [EXP_W-1:0]  exp_f;
   logic [FRAC_W-1:0] frac_f;
   logic              exp_ones;
   logic              frac_nz;
   logic              quiet_bit;

   assign exp_f    = val_i[W-2 -: EXP_W];
   assign frac_f   = val_i[FRAC_W-1:0];
   assign exp_ones = &exp_f;
   assign frac_nz  = |frac_f;

   // polarity of the quiet marker is a build option
   generate
      if (QUIET_MSB_SET) begin : g_q_hi
         assign quiet_bit = frac_f[FRAC_W-1];
      end else begin : g_q_lo
         assign quiet_bit = ~frac_f[FRAC_W-1];
      end
   endgenerate

   always_comb begin
      cls_o.sign = val_i[W-1];
      cls_o.zero = ~|val_i[W-2:0];
      cls_o.nan  = exp_ones & frac_nz;
      cls_o.snan = exp_ones & frac_nz & ~quiet_bit;
   end

endmodule

// File: rtl/fcmp_order.sv
`timescale 1ns/1ps
module fcmp_order
   import fcmp_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic [EXP_W+FRAC_W:0] a_i,
   input  logic [EXP_W+FRAC_W:0] b_i,
   input  fcmp_cls_t             a_cls_i,
   input  fcmp_cls_t             b_cls_i,
   output logic                  a_lt_b_o,
   output logic                  b_lt_a_o,
   output logic                  a_eq_b_o
);

   localparam int W   = 1 + EXP_W + FRAC_W;
   localparam int M_W = W - 1;

   logic              any_nan;
   logic              both_zero;
   logic [1:0]        lt_dir;

   assign any_nan   = a_cls_i.nan | b_cls_i.nan;
   assign both_zero = a_cls_i.zero & b_cls_i.zero;

   // one strict less-than core per direction: d=0 is a<b, d=1 is b<a
   generate
      for (genvar d = 0; d < 2; d++) begin : g_dir
         logic [W-1:0]   x_v;
         logic [W-1:0]   y_v;
         logic [M_W-1:0] x_m;
         logic [M_W-1:0] y_m;
         logic           x_neg;
         logic           y_neg;
         logic           lt_raw;

         assign x_v   = (d == 0) ? a_i : b_i;
         assign y_v   = (d == 0) ? b_i : a_i;
         assign x_m   = x_v[M_W-1:0];
         assign y_m   = y_v[M_W-1:0];
         assign x_neg = x_v[W-1];
         assign y_neg = y_v[W-1];

         always_comb begin
            if (both_zero) begin
               lt_raw = 1'b0;
            end else if (x_neg != y_neg) begin
               lt_raw = x_neg;
            end else if (!x_neg) begin
               lt_raw = (x_m < y_m);
            end else begin
               lt_raw = (x_m > y_m);
            end
         end

         assign lt_dir[d] = lt_raw & ~any_nan;
      end
   endgenerate

   assign a_lt_b_o = lt_dir[0];
   assign b_lt_a_o = lt_dir[1];
   assign a_eq_b_o = ~any_nan & (both_zero | (a_i == b_i));

endmodule

// File: rtl/fcmp_status.sv
`timescale 1ns/1ps
module fcmp_status (
   input  logic clk,
   input  logic rst_n,
   input  logic valid_i,
   input  logic inv_i,
   input  logic exc_en_i,
   input  logic cfg_en_i,
   output logic sticky_o,
   output logic req_o
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sticky_o <= 1'b0;
         req_o    <= 1'b0;
      end else begin
         if (valid_i && inv_i) begin
            sticky_o <= 1'b1;
         end
         req_o <= valid_i & inv_i & exc_en_i & cfg_en_i;
      end
   end

endmodule

// File: rtl/fcmp_unit.sv
`timescale 1ns/1ps
module fcmp_unit
   import fcmp_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  valid_i,
   input  logic [2:0]            op_i,
   input  logic [EXP_W+FRAC_W:0] a_i,
   input  logic [EXP_W+FRAC_W:0] b_i,
   input  logic                  exc_en_i,
   input  logic                  fpu_exc_cfg_i,
   output logic                  result_o,
   output logic                  inv_sticky_o,
   output logic                  exc_req_o
);

   localparam int W = 1 + EXP_W + FRAC_W;

   generate
      if (EXP_W < 2) begin : g_bad_exp
         $error("fcmp_unit: EXP_W must be at least 2");
      end
      if (FRAC_W < 2) begin : g_bad_frac
         $error("fcmp_unit: FRAC_W must be at least 2");
      end
   endgenerate

   fcmp_cls_t cls [2];
   logic [W-1:0] opnd [2];

   assign opnd[0] = a_i;
   assign opnd[1] = b_i;

   generate
      for (genvar k = 0; k < 2; k++) begin : g_cls
         fcmp_classify #(
            .EXP_W         (EXP_W),
            .FRAC_W        (FRAC_W),
            .QUIET_MSB_SET (1'b1)
         ) u_cls (
            .val_i (opnd[k]),
            .cls_o (cls[k])
         );
      end
   endgenerate

   logic a_lt_b;
   logic b_lt_a;
   logic a_eq_b;

   fcmp_order #(
      .EXP_W  (EXP_W),
      .FRAC_W (FRAC_W)
   ) u_order (
      .a_i      (a_i),
      .b_i      (b_i),
      .a_cls_i  (cls[0]),
      .b_cls_i  (cls[1]),
      .a_lt_b_o (a_lt_b),
      .b_lt_a_o (b_lt_a),
      .a_eq_b_o (a_eq_b)
   );

   logic      any_nan;
   logic      any_snan;
   fcmp_out_t nxt;

   assign any_nan  = cls[0].nan  | cls[1].nan;
   assign any_snan = cls[0].snan | cls[1].snan;

   always_comb begin
      nxt = '0;
      unique case (fcmp_op_e'(op_i))
         OP_UNORD: begin nxt.res = any_nan;           nxt.inv = any_snan; end
         OP_LT:    begin nxt.res = b_lt_a;            nxt.inv = any_nan;  end
         OP_EQ:    begin nxt.res = a_eq_b;            nxt.inv = any_snan; end
         OP_LE:    begin nxt.res = a_lt_b | a_eq_b;   nxt.inv = any_nan;  end
         OP_GT:    begin nxt.res = a_lt_b;            nxt.inv = any_nan;  end
         OP_NE:    begin nxt.res = ~a_eq_b;           nxt.inv = any_snan; end
         OP_GE:    begin nxt.res = ~a_lt_b;           nxt.inv = any_nan;  end
         OP_RSVD:  begin nxt.res = 1'b0;              nxt.inv = 1'b0;     end
         default:  begin nxt.res = 1'b0;              nxt.inv = 1'b0;     end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         result_o <= 1'b0;
      end else if (valid_i) begin
         result_o <= nxt.res;
      end
   end

   fcmp_status u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid_i  (valid_i),
      .inv_i    (nxt.inv),
      .exc_en_i (exc_en_i),
      .cfg_en_i (fpu_exc_cfg_i),
      .sticky_o (inv_sticky_o),
      .req_o    (exc_req_o)
   );

endmodule

// File: rtl/fcmp_unit_chk.sv
`timescale 1ns/1ps
module fcmp_unit_chk #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  valid_i,
   input logic [2:0]            op_i,
   input logic [EXP_W+FRAC_W:0] a_i,
   input logic [EXP_W+FRAC_W:0] b_i,
   input logic                  exc_en_i,
   input logic                  fpu_exc_cfg_i,
   input logic                  result_o,
   input logic                  inv_sticky_o,
   input logic                  exc_req_o
);

   localparam int W = 1 + EXP_W + FRAC_W;

   logic a_is_nan;
   logic b_is_nan;
   logic ordered_op;

   assign a_is_nan   = (&a_i[W-2 -: EXP_W]) && (|a_i[FRAC_W-1:0]);
   assign b_is_nan   = (&b_i[W-2 -: EXP_W]) && (|b_i[FRAC_W-1:0]);
   assign ordered_op = (op_i == 3'd1) || (op_i == 3'd3) ||
                       (op_i == 3'd4) || (op_i == 3'd6);

   p_unord_nan_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i == 3'd0 && (a_is_nan || b_is_nan)) |=> result_o);

   p_ordered_nan_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && ordered_op && (a_is_nan || b_is_nan)) |=> inv_sticky_o);

   p_sticky_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      inv_sticky_o |=> inv_sticky_o);

   p_req_enables_r8: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req_o |-> ($past(valid_i) && $past(exc_en_i) && $past(fpu_exc_cfg_i)));

   p_req_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      exc_req_o |-> inv_sticky_o);

   p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !valid_i |=> ($stable(result_o) && !exc_req_o));

   p_rsvd_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_i && op_i == 3'd7) |=> !result_o);

endmodule

bind fcmp_unit fcmp_unit_chk #(
   .EXP_W  (EXP_W),
   .FRAC_W (FRAC_W)
) u_fcmp_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .valid_i       (valid_i),
   .op_i          (op_i),
   .a_i           (a_i),
   .b_i           (b_i),
   .exc_en_i      (exc_en_i),
   .fpu_exc_cfg_i (fpu_exc_cfg_i),
   .result_o      (result_o),
   .inv_sticky_o  (inv_sticky_o),
   .exc_req_o     (exc_req_o)
);

// File: tb/tb_fcmp_unit.sv
`timescale 1ns/1ps
module tb_fcmp_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        valid_i = 1'b0;
   logic [2:0]  op_i = '0;
   logic [31:0] a_i = '0;
   logic [31:0] b_i = '0;
   logic        exc_en_i = 1'b0;
   logic        fpu_exc_cfg_i = 1'b0;
   logic        result_o;
   logic        inv_sticky_o;
   logic        exc_req_o;

   always #5 clk = ~clk;

   fcmp_unit dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .valid_i       (valid_i),
      .op_i          (op_i),
      .a_i           (a_i),
      .b_i           (b_i),
      .exc_en_i      (exc_en_i),
      .fpu_exc_cfg_i (fpu_exc_cfg_i),
      .result_o      (result_o),
      .inv_sticky_o  (inv_sticky_o),
      .exc_req_o     (exc_req_o)
   );

   typedef struct {
      logic  res;
      logic  sticky;
      logic  req;
      string tag;
   } exp_t;

   exp_t q[$];
   int   checks   = 0;
   int   failures = 0;
   bit   done     = 0;
   logic m_sticky = 1'b0;
   logic m_res    = 1'b0;

   task automatic check(input logic act, input logic expv, input string what);
      checks++;
      if (act !== expv) begin
         failures++;
         $display("FAIL %s actual=%0b expected=%0b", what, act, expv);
      end
   endtask

   // reference model (R9, R10): NaN decode and signed ordering key
   function automatic logic m_nan(input logic [31:0] x);
      return (x[30:23] == 8'hFF) && (x[22:0] != 0);
   endfunction
   function automatic logic m_snan(input logic [31:0] x);
      return m_nan(x) && !x[22];
   endfunction
   function automatic int m_key(input logic [31:0] x);
      int mag;
      mag = int'({1'b0, x[30:0]});
      return x[31] ? -mag : mag;
   endfunction

   task automatic model(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                        output logic res, output logic inv);
      logic an, sn, alb, bla, eq;
      an  = m_nan(a) || m_nan(b);
      sn  = m_snan(a) || m_snan(b);
      alb = !an && (m_key(a) < m_key(b));
      bla = !an && (m_key(b) < m_key(a));
      eq  = !an && (m_key(a) == m_key(b));
      case (op)
         3'd0: begin res = an;         inv = sn; end
         3'd1: begin res = bla;        inv = an; end
         3'd2: begin res = eq;         inv = sn; end
         3'd3: begin res = alb || eq;  inv = an; end
         3'd4: begin res = alb;        inv = an; end
         3'd5: begin res = !eq;        inv = sn; end
         3'd6: begin res = !alb;       inv = an; end
         default: begin res = 1'b0;    inv = 1'b0; end
      endcase
   endtask

   function automatic string op_req(input logic [2:0] op);
      case (op)
         3'd0: return "R1";
         3'd1: return "R2";
         3'd2: return "R5";
         3'd3: return "R4";
         3'd4: return "R3";
         3'd5: return "R5";
         3'd6: return "R3";
         default: return "R12";
      endcase
   endfunction

   // driver: one strobe, expected item pushed to the scoreboard
   task automatic cmp(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                      input logic en, input logic cfg, input string tag);
      logic r, inv;
      exp_t e;
      model(op, a, b, r, inv);
      if (inv) m_sticky = 1'b1;
      m_res    = r;
      e.res    = r;
      e.sticky = m_sticky;
      e.req    = inv && en && cfg;
      e.tag    = $sformatf("%s op=%0d a=%h b=%h", tag, op, a, b);
      @(negedge clk);
      op_i = op; a_i = a; b_i = b; exc_en_i = en; fpu_exc_cfg_i = cfg;
      valid_i = 1'b1;
      q.push_back(e);
      @(negedge clk);
      valid_i = 1'b0;
   endtask

   // monitor: pops and compares one item per accepted strobe
   initial begin
      forever begin
         @(posedge clk);
         if (rst_n && valid_i) begin
            exp_t e;
            #2;
            if (q.size() == 0) begin
               checks++; failures++;
               $display("FAIL R11 scoreboard empty actual=1 expected=0");
            end else begin
               e = q.pop_front();
               check(result_o, e.res, {"result ", e.tag});
               check(inv_sticky_o, e.sticky, {"R7 sticky ", e.tag});
               check(exc_req_o, e.req, {"R8 req ", e.tag});
            end
         end
      end
   end

   // idle cycle: result holds and no request (R11)
   task automatic idle_check();
      @(negedge clk);
      @(negedge clk);
      check(result_o, m_res, "R11 result hold while idle");
      check(exc_req_o, 1'b0, "R11 no request while idle");
      check(inv_sticky_o, m_sticky, "R7 sticky hold while idle");
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; valid_i = 1'b0;
      repeat (2) @(negedge clk);
      check(result_o, 1'b0, "R11 reset result");
      check(inv_sticky_o, 1'b0, "R11 reset sticky");
      check(exc_req_o, 1'b0, "R11 reset req");
      rst_n = 1'b1;
      m_sticky = 1'b0;
      m_res = 1'b0;
   endtask

   localparam logic [31:0] P_ONE  = 32'h3F80_0000;
   localparam logic [31:0] P_TWO  = 32'h4000_0000;
   localparam logic [31:0] N_ONE  = 32'hBF80_0000;
   localparam logic [31:0] N_TWO  = 32'hC000_0000;
   localparam logic [31:0] P_ZERO = 32'h0000_0000;
   localparam logic [31:0] N_ZERO = 32'h8000_0000;
   localparam logic [31:0] P_INF  = 32'h7F80_0000;
   localparam logic [31:0] N_INF  = 32'hFF80_0000;
   localparam logic [31:0] QNAN   = 32'h7FC0_0000;
   localparam logic [31:0] SNAN   = 32'h7F80_0001;
   localparam logic [31:0] DENORM = 32'h0000_0001;

   logic [31:0] vals [11];

   initial begin
      vals = '{P_ONE, P_TWO, N_ONE, N_TWO, P_ZERO, N_ZERO, P_INF, N_INF, QNAN, SNAN, DENORM};
      do_reset();

      // directed: operand order and quiet/signaling flagging
      cmp(3'd1, P_ONE, P_TWO, 1, 1, "R2 lt is B<A false");
      cmp(3'd1, P_TWO, P_ONE, 1, 1, "R2 lt is B<A true");
      cmp(3'd4, P_ONE, P_TWO, 1, 1, "R3 gt is A<B");
      cmp(3'd3, P_ONE, P_ONE, 1, 1, "R4 le equal");
      cmp(3'd2, P_ZERO, N_ZERO, 1, 1, "R9 zeros equal");
      cmp(3'd2, QNAN, P_ONE, 1, 1, "R5 eq quiet nan no flag");
      cmp(3'd5, QNAN, P_ONE, 1, 1, "R5 ne quiet nan true");
      cmp(3'd0, QNAN, QNAN, 1, 1, "R1 unord quiet no flag");
      cmp(3'd7, P_ONE, P_ONE, 1, 1, "R12 reserved");
      cmp(3'd4, QNAN, P_ONE, 1, 0, "R8 cfg off no req");
      cmp(3'd6, P_ONE, P_ONE, 1, 1, "R7 sticky after clean");
      idle_check();
      do_reset();
      cmp(3'd0, SNAN, P_ONE, 1, 1, "R10 snan unord flags");
      cmp(3'd6, QNAN, P_ONE, 1, 1, "R6 ge nan true with req");
      idle_check();

      // sweep every code over all pairs, rotating enables
      do_reset();
      begin
         int n = 0;
         for (int op = 0; op < 8; op++) begin
            for (int i = 0; i < 11; i++) begin
               for (int j = 0; j < 11; j++) begin
                  cmp(3'(op), vals[i], vals[j], n[0], n[1], op_req(3'(op)));
                  n++;
               end
            end
            idle_check();
         end
      end

      repeat (3) @(negedge clk);
      if (q.size() != 0) begin
         checks++; failures++;
         $display("FAIL R11 leftover items actual=%0d expected=0", q.size());
      end
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1;
         checks++; failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule